// File: doc/BRIEF.md
# Element-Serial Vector Execution Unit

The unit keeps a bank of vector registers and carries out one register-to-register integer vector instruction at a time. After an instruction is accepted over a ready/valid handshake, the sequencer sends one element index per cycle into a three-stage functional unit. That unit reads the operands, computes the result and then writes it back. Element-wise add and multiply write a full vector into the destination register. Compare and accumulate instead fold the source vectors into one 64-bit scalar and leave every register untouched.

The register bank also has an element write port and an element read port for a neighbouring load/store pipe. The write port is honoured only while the unit is idle. The read port is combinational. When an instruction finishes, `done_o` pulses for one cycle. `scalar_o` keeps its value until the next instruction is accepted.

Top module: `vec_unit`

## Requirements
- R1: After reset, in_ready_o is 1, done_o is 0 and scalar_o is 0.
- R2: Opcode 0 (add) writes vd[i] = vs2[i] + vs1[i] modulo 2^64 for every element i below the length.
- R3: Opcode 1 (multiply) writes vd[i] = low 64 bits of vs2[i] * vs1[i] for every element i below the length.
- R4: Opcode 2 (compare) sets scalar_o bit i to 1 when vs2[i] < vs1[i] as signed numbers, for i below the length. Higher bits are 0 and no register changes.
- R5: Opcode 3 (accumulate) gives scalar_o = sum of vs2[i] over i below the length, modulo 2^64. vs1 is not used and no register changes.
- R6: The length field is 6 bits wide and 0 encodes 64. Destination elements at or above the length, and all other registers, keep their values.
- R7: in_ready_o is 0 from the accepting edge until done_o. A request presented in that window is dropped.
- R8: done_o rises exactly len+2 clock edges after the accepting edge and stays high for one cycle only.
- R9: Opcodes are encoded in in_op_i as 0 add, 1 multiply, 2 compare, 3 accumulate.
- R10: An external element write takes effect only when in_ready_o is 1 and is ignored while an instruction is in flight. The external read port returns the addressed element combinationally.
- R11: A destination that equals one or both sources gives the same element-wise result as separate registers would.
- R12: scalar_o is cleared when an instruction is accepted and holds its final value until the next acceptance. It stays 0 for add and multiply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction request |
| in_ready_o | output | 1 | Unit idle, request will be taken |
| in_op_i | input | 2 | Opcode |
| in_vd_i | input | 3 | Destination register |
| in_vs2_i | input | 3 | First source register |
| in_vs1_i | input | 3 | Second source register |
| in_len_i | input | 6 | Element count, 0 means 64 |
| done_o | output | 1 | One-cycle completion pulse |
| scalar_o | output | 64 | Compare mask or accumulated sum |
| ext_we_i | input | 1 | External element write enable |
| ext_wreg_i | input | 3 | External write register |
| ext_widx_i | input | 6 | External write element index |
| ext_wdata_i | input | 64 | External write data |
| ext_rreg_i | input | 3 | External read register |
| ext_ridx_i | input | 6 | External read element index |
| ext_rdata_o | output | 64 | External read data |

## Verification
The assertions check the following on every cycle: the ready/done protocol, that each pipeline stage advances one step per cycle, that issue never runs past the length, that the two write ports never collide, and that the scalar stays frozen while idle. Only the bench scenarios can show the arithmetic results, the exact completion latency for each length, that elements beyond the length are preserved, in-place operation, and that writes and requests arriving mid-instruction are dropped. The bench computes each of these against a model of all 512 register elements.

// File: rtl/vu_pkg.sv
package vu_pkg;
  typedef enum logic [1:0] {
    VOP_ADD = 2'd0,
    VOP_MUL = 2'd1,
    VOP_CMP = 2'd2,
    VOP_ACC = 2'd3
  } vop_e;

  function automatic logic vop_writes(vop_e op);
    return (op == VOP_ADD) || (op == VOP_MUL);
  endfunction
endpackage

// File: rtl/vec_regfile.sv
module vec_regfile #(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int DW    = 64,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(NREG) + $clog2(NELEM),
  localparam int DEPTH = NREG * NELEM
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_a_i,
  input  logic [AW-1:0] waddr_a_i,
  input  logic [DW-1:0] wdata_a_i,
  input  logic          we_b_i,
  input  logic [AW-1:0] waddr_b_i,
  input  logic [DW-1:0] wdata_b_i,
  input  logic [AW-1:0] raddr_i [NRD],
  output logic [DW-1:0] rdata_o [NRD]
);
  logic [DW-1:0] mem_q [DEPTH];

  // port a (execution) wins over port b on the same address
  always_ff @(posedge clk_i) begin
    if (we_a_i) mem_q[waddr_a_i] <= wdata_a_i;
    if (we_b_i && !(we_a_i && (waddr_a_i == waddr_b_i))) mem_q[waddr_b_i] <= wdata_b_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end

  a_r10_ports_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_a_i && we_b_i));
endmodule

// File: rtl/vec_fu.sv
module vec_fu import vu_pkg::*; #(
  parameter int DW = 64,
  parameter int EW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  vop_e          in_op_i,
  input  logic [EW-1:0] in_idx_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic          out_valid_o,
  output vop_e          out_op_o,
  output logic [EW-1:0] out_idx_o,
  output logic [DW-1:0] out_res_o
);
  logic          v1_q;
  vop_e          op1_q;
  logic [EW-1:0] idx1_q;
  logic [DW-1:0] a1_q, b1_q, res_d;

  // stage 1: operand capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q   <= 1'b0;
      op1_q  <= VOP_ADD;
      idx1_q <= '0;
      a1_q   <= '0;
      b1_q   <= '0;
    end else begin
      v1_q <= in_valid_i;
      if (in_valid_i) begin
        op1_q  <= in_op_i;
        idx1_q <= in_idx_i;
        a1_q   <= a_i;
        b1_q   <= b_i;
      end
    end
  end

  always_comb begin
    unique case (op1_q)
      VOP_ADD: res_d = a1_q + b1_q;
      VOP_MUL: res_d = a1_q * b1_q;
      VOP_CMP: res_d = {{(DW-1){1'b0}}, ($signed(a1_q) < $signed(b1_q))};
      VOP_ACC: res_d = a1_q;
    endcase
  end

  // stage 2: result register, feeds write-back
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_op_o    <= VOP_ADD;
      out_idx_o   <= '0;
      out_res_o   <= '0;
    end else begin
      out_valid_o <= v1_q;
      if (v1_q) begin
        out_op_o  <= op1_q;
        out_idx_o <= idx1_q;
        out_res_o <= res_d;
      end
    end
  end

  a_r8_stage_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v1_q |=> out_valid_o);
  a_r8_no_bubble_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(v1_q));
endmodule

// File: rtl/vec_ctrl.sv
module vec_ctrl import vu_pkg::*; #(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int DW    = 64,
  localparam int RW   = $clog2(NREG),
  localparam int EW   = $clog2(NELEM)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [1:0]    in_op_i,
  input  logic [RW-1:0] in_vd_i,
  input  logic [RW-1:0] in_vs2_i,
  input  logic [RW-1:0] in_vs1_i,
  input  logic [EW-1:0] in_len_i,
  input  logic          wb_valid_i,
  input  vop_e          wb_op_i,
  input  logic [EW-1:0] wb_idx_i,
  input  logic [DW-1:0] wb_res_i,
  output logic          iss_valid_o,
  output vop_e          iss_op_o,
  output logic [EW-1:0] iss_idx_o,
  output logic [RW-1:0] src2_reg_o,
  output logic [RW-1:0] src1_reg_o,
  output logic          wr_en_o,
  output logic [RW-1:0] wr_reg_o,
  output logic [EW-1:0] wr_idx_o,
  output logic [DW-1:0] wr_data_o,
  output logic          done_o,
  output logic [DW-1:0] scalar_o
);
  logic          busy_q, iss_on_q, done_q, accept;
  vop_e          op_q;
  logic [RW-1:0] vd_q, vs2_q, vs1_q;
  logic [EW-1:0] last_q, iss_cnt_q;
  logic [DW-1:0] scal_q;

  assign accept = in_valid_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      iss_on_q  <= 1'b0;
      done_q    <= 1'b0;
      op_q      <= VOP_ADD;
      vd_q      <= '0;
      vs2_q     <= '0;
      vs1_q     <= '0;
      last_q    <= '0;
      iss_cnt_q <= '0;
      scal_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q    <= 1'b1;
        iss_on_q  <= 1'b1;
        op_q      <= vop_e'(in_op_i);
        vd_q      <= in_vd_i;
        vs2_q     <= in_vs2_i;
        vs1_q     <= in_vs1_i;
        last_q    <= in_len_i - 1'b1;  // len 0 wraps to NELEM-1
        iss_cnt_q <= '0;
        scal_q    <= '0;
      end else if (iss_on_q) begin
        iss_cnt_q <= iss_cnt_q + 1'b1;
        if (iss_cnt_q == last_q) iss_on_q <= 1'b0;
      end
      if (wb_valid_i) begin
        if (wb_op_i == VOP_CMP)      scal_q[wb_idx_i] <= wb_res_i[0];
        else if (wb_op_i == VOP_ACC) scal_q <= scal_q + wb_res_i;
        if (wb_idx_i == last_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign in_ready_o  = !busy_q;
  assign iss_valid_o = iss_on_q;
  assign iss_op_o    = op_q;
  assign iss_idx_o   = iss_cnt_q;
  assign src2_reg_o  = vs2_q;
  assign src1_reg_o  = vs1_q;
  assign wr_en_o     = wb_valid_i && vop_writes(wb_op_i);
  assign wr_reg_o    = vd_q;
  assign wr_idx_o    = wb_idx_i;
  assign wr_data_o   = wb_res_i;
  assign done_o      = done_q;
  assign scalar_o    = scal_q;

  a_r7_ready_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> !in_ready_o);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> in_ready_o);
  a_r6_issue_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_on_q |-> (busy_q && (iss_cnt_q <= last_q)));
  a_r8_wb_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |-> busy_q);
  a_r12_scalar_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !in_valid_i) |=> $stable(scalar_o));
endmodule

// File: rtl/vec_unit.sv
module vec_unit import vu_pkg::*; #(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int DW    = 64,
  localparam int RW   = $clog2(NREG),
  localparam int EW   = $clog2(NELEM),
  localparam int AW   = RW + EW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [1:0]    in_op_i,
  input  logic [RW-1:0] in_vd_i,
  input  logic [RW-1:0] in_vs2_i,
  input  logic [RW-1:0] in_vs1_i,
  input  logic [EW-1:0] in_len_i,
  output logic          done_o,
  output logic [DW-1:0] scalar_o,
  input  logic          ext_we_i,
  input  logic [RW-1:0] ext_wreg_i,
  input  logic [EW-1:0] ext_widx_i,
  input  logic [DW-1:0] ext_wdata_i,
  input  logic [RW-1:0] ext_rreg_i,
  input  logic [EW-1:0] ext_ridx_i,
  output logic [DW-1:0] ext_rdata_o
);
  logic          iss_valid, wb_valid, wr_en;
  vop_e          iss_op, wb_op;
  logic [EW-1:0] iss_idx, wb_idx, wr_idx;
  logic [RW-1:0] src2_reg, src1_reg, wr_reg;
  logic [DW-1:0] wb_res, wr_data;
  logic [AW-1:0] rf_raddr [3];
  logic [DW-1:0] rf_rdata [3];

  assign rf_raddr[0] = {src2_reg, iss_idx};
  assign rf_raddr[1] = {src1_reg, iss_idx};
  assign rf_raddr[2] = {ext_rreg_i, ext_ridx_i};
  assign ext_rdata_o = rf_rdata[2];

  vec_ctrl #(.NREG(NREG), .NELEM(NELEM), .DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .in_op_i, .in_vd_i, .in_vs2_i,
    .in_vs1_i, .in_len_i,
    .wb_valid_i (wb_valid), .wb_op_i (wb_op), .wb_idx_i (wb_idx), .wb_res_i (wb_res),
    .iss_valid_o(iss_valid), .iss_op_o (iss_op), .iss_idx_o (iss_idx),
    .src2_reg_o (src2_reg), .src1_reg_o (src1_reg),
    .wr_en_o (wr_en), .wr_reg_o (wr_reg), .wr_idx_o (wr_idx), .wr_data_o (wr_data),
    .done_o, .scalar_o
  );

  vec_fu #(.DW(DW), .EW(EW)) u_fu (
    .clk_i, .rst_ni,
    .in_valid_i (iss_valid), .in_op_i (iss_op), .in_idx_i (iss_idx),
    .a_i (rf_rdata[0]), .b_i (rf_rdata[1]),
    .out_valid_o(wb_valid), .out_op_o (wb_op), .out_idx_o (wb_idx), .out_res_o (wb_res)
  );

  vec_regfile #(.NREG(NREG), .NELEM(NELEM), .DW(DW), .NRD(3)) u_rf (
    .clk_i, .rst_ni,
    .we_a_i (wr_en), .waddr_a_i ({wr_reg, wr_idx}), .wdata_a_i (wr_data),
    .we_b_i (ext_we_i && in_ready_o), .waddr_b_i ({ext_wreg_i, ext_widx_i}),
    .wdata_b_i (ext_wdata_i),
    .raddr_i (rf_raddr), .rdata_o (rf_rdata)
  );
endmodule

// File: tb/vec_unit_bench.sv
`timescale 1ns/1ps
module vec_unit_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready, done, ext_we = 1'b0;
  logic [1:0]  in_op = '0;
  logic [2:0]  in_vd = '0, in_vs2 = '0, in_vs1 = '0, ext_wreg = '0, ext_rreg = '0;
  logic [5:0]  in_len = '0, ext_widx = '0, ext_ridx = '0;
  logic [63:0] scalar, ext_wdata = '0, ext_rdata;

  logic [63:0] mdl  [8][64];
  logic [63:0] emdl [8][64];
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  vec_unit u_vec_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_op_i(in_op), .in_vd_i(in_vd), .in_vs2_i(in_vs2), .in_vs1_i(in_vs1),
    .in_len_i(in_len), .done_o(done), .scalar_o(scalar),
    .ext_we_i(ext_we), .ext_wreg_i(ext_wreg), .ext_widx_i(ext_widx),
    .ext_wdata_i(ext_wdata), .ext_rreg_i(ext_rreg), .ext_ridx_i(ext_ridx),
    .ext_rdata_o(ext_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int r, input int i, input int seed);
    logic [63:0] x;
    x = (64'(r) * 64'd977 + 64'(i) * 64'd131 + 64'(seed) + 64'd1) * 64'h9E3779B97F4A7C15;
    return x ^ (x >> 29);
  endfunction

  task automatic ext_write(input int r, input int i, input logic [63:0] d);
    @(negedge clk);
    ext_we = 1'b1; ext_wreg = 3'(r); ext_widx = 6'(i); ext_wdata = d;
    @(posedge clk); #1;
    ext_we = 1'b0;
  endtask

  // compare every element against emdl; split in-range vd elements from the rest
  task automatic check_regs(input int vd, input int n, input bit wr, input string req_in, input string req_out);
    int mi = 0, mo = 0;
    logic [63:0] ai = '0, ei = '0, ao = '0, eo = '0;
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) begin
        ext_rreg = 3'(r); ext_ridx = 6'(i); #0.1;
        if (ext_rdata !== emdl[r][i]) begin
          if (wr && r == vd && i < n) begin
            if (mi == 0) begin ai = ext_rdata; ei = emdl[r][i]; end
            mi++;
          end else begin
            if (mo == 0) begin ao = ext_rdata; eo = emdl[r][i]; end
            mo++;
          end
        end
      end
    if (wr) chk(mi == 0, req_in, ai, ei);
    chk(mo == 0, req_out, ao, eo);
  endtask

  task automatic run(input int op, input int vd, input int vs2, input int vs1, input int len, input bit inject);
    int n, lat;
    bit got, wr;
    logic [63:0] escal, a, b;
    string req;
    n  = (len == 0) ? 64 : len;
    wr = (op < 2);
    emdl = mdl;
    escal = '0;
    for (int i = 0; i < n; i++) begin
      a = mdl[vs2][i]; b = mdl[vs1][i];
      case (op)
        0: emdl[vd][i] = a + b;
        1: emdl[vd][i] = a * b;
        2: escal[i] = ($signed(a) < $signed(b));
        default: escal = escal + a;
      endcase
    end
    case (op)
      0: req = "R2 R9 add";
      1: req = "R3 R9 mul";
      2: req = "R4 R9 cmp";
      default: req = "R5 R9 acc";
    endcase
    @(negedge clk);
    chk(in_ready === 1'b1, "R7 ready before issue", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_op = 2'(op); in_vd = 3'(vd); in_vs2 = 3'(vs2); in_vs1 = 3'(vs1); in_len = 6'(len);
    @(posedge clk); #1;
    in_valid = 1'b0;
    lat = 0; got = 0;
    while (!got && lat < 200) begin
      if (inject && lat == 1) begin
        // competing request and external write while busy: both must be dropped (R7, R10)
        in_valid = 1'b1; in_op = 2'd0; in_vd = 3'd7; in_vs2 = 3'(vs2); in_vs1 = 3'(vs1); in_len = 6'd0;
        ext_we = 1'b1; ext_wreg = 3'd7; ext_widx = 6'd5; ext_wdata = ~mdl[7][5];
      end
      if (inject && lat == 2) begin in_valid = 1'b0; ext_we = 1'b0; end
      @(posedge clk); lat++; #1;
      if (done) got = 1;
    end
    in_valid = 1'b0; ext_we = 1'b0;
    chk(got && lat == n + 2, "R8 done latency", 64'(lat), 64'(n + 2));
    @(posedge clk); #1;
    chk(done === 1'b0, "R8 done one cycle", 64'(done), 64'd0);
    chk(scalar === escal, {req, " scalar R12"}, scalar, escal);
    check_regs(vd, n, wr, {req, " elements"}, inject ? "R6 R7 R10 untouched" : "R6 untouched");
    chk(scalar === escal, "R12 scalar held", scalar, escal);
    mdl = emdl;
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens [5] = '{1, 2, 31, 63, 0};
    repeat (3) @(posedge clk);
    #1;
    chk(in_ready === 1'b1, "R1 ready", 64'(in_ready), 64'd1);
    chk(done === 1'b0, "R1 done", 64'(done), 64'd0);
    chk(scalar === 64'd0, "R1 scalar", scalar, 64'd0);
    rst_n = 1'b1;
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) begin
        mdl[r][i] = pat(r, i, 0);
        ext_write(r, i, mdl[r][i]);
      end
    emdl = mdl;
    check_regs(0, 0, 1'b0, "R10", "R10 idle write and read back");
    for (int op = 0; op < 4; op++)
      for (int li = 0; li < 5; li++)
        run(op, (op * 3 + li) % 8, (li + 1) % 8, (op + li + 4) % 8, lens[li], li == 2);
    // R11: destination aliases both sources
    run(0, 3, 3, 3, 0, 1'b0);
    run(1, 5, 5, 2, 40, 1'b0);
    chk(in_ready === 1'b1, "R11 R7 idle at end", 64'(in_ready), 64'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule